// File: doc/BRIEF.md
# Page Write Buffer with Deferred Timed Commit

This block sits between the serial protocol engine of a byte-addressed nonvolatile memory and its storage array. A write transaction opens with a start pulse that carries the full target address. The upper address bits choose a 64-byte page and the low six bits give the first byte offset. Data bytes then arrive on a valid/ready stream. Each accepted byte goes into a page-sized holding buffer at a running offset. That offset advances by one per byte and wraps inside the page. Each buffer slot has a flag that records whether it was loaded.

Nothing reaches the array until the protocol engine pulses the stop input. At that point, if write protect is low and at least one byte is held, the block enters a busy period of exactly `BUSY_CYCLES` clock cycles. Early in that period it sends each loaded byte to the array, one per clock, in ascending offset order. While busy it ignores every request. The protocol engine reads the busy flag to decide whether to answer its device address. Back-pressure rules: a byte transfers only in a cycle where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` is low while busy, and also in any cycle that carries a transaction start or a stop pulse. A source holds `in_valid_i` and `in_data_i` until the transfer takes place.

Top module: `pgb_page_commit`

## Requirements
- R1: Array addresses produced by a commit are the page bits latched from `txn_addr_i[ADDR_W-1:6]` at the transaction start, concatenated with the 6-bit slot offset. The first byte lands at offset `txn_addr_i[5:0]`, and each later accepted byte lands one offset higher.
- R2: After offset 63 the next accepted byte goes to offset 0 of the same page. A byte written to an already loaded offset replaces the earlier byte there.
- R3: No array write occurs before the stop pulse. Loaded bytes are held in the buffer, and `arr_we_o` is high only while `busy_o` is high.
- R4: A commit writes exactly the loaded offsets, one per clock in strictly ascending offset order, on consecutive cycles. The first write is in the cycle right after the clock edge that samples the stop.
- R5: `busy_o` rises in the cycle after an accepted stop and stays high for exactly `BUSY_CYCLES` cycles.
- R6: While `busy_o` is high, `in_ready_o` is low and transaction starts, data and stop pulses have no effect.
- R7: A stop sampled with `wp_i` high starts no busy period and no array write, and it discards the loaded bytes.
- R8: A stop with no loaded byte (an address-only transaction) starts no busy period and no array write.
- R9: A transaction start discards any bytes loaded before it, so only bytes of the latest transaction are committed.
- R10: After a commit no slot stays loaded, and a further stop with no new bytes writes nothing.
- R11: After reset `busy_o` and `arr_we_o` are low and `in_ready_o` is high.
- R12: `in_ready_o` is low in any cycle where `txn_start_i` or `stop_i` is high, so no byte is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start_i | input | 1 | Pulse opening a write transaction |
| txn_addr_i | input | ADDR_W | Full start address sampled with the start pulse |
| in_valid_i | input | 1 | Data byte offered |
| in_ready_o | output | 1 | Block can take the offered byte |
| in_data_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Pulse marking the stop that ends a write |
| wp_i | input | 1 | Write-protect level, high blocks the commit |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Program period in progress |

## Verification
The bound checker watches every cycle. It checks that array strobes occur only while busy and that ready stays low while busy or during a start. It checks that busy rises only after a stop and is never entered on a protected stop. It checks that successive commit writes stay in one page with rising offsets, and it counts each busy period to confirm its exact length. The stored contents need the directed scenarios to show: wrap-around replacement, discarding on a new start or under protection, the cycle of the first write relative to the stop, and the absence of writes after a commit or an address-only transaction.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
  typedef enum logic [1:0] {
    PGB_IDLE   = 2'd0,
    PGB_COMMIT = 2'd1,
    PGB_HOLD   = 2'd2
  } pgb_state_e;
endpackage

// File: rtl/pgb_lowest_set.sv
// Finds the lowest set bit of a vector through a prefix-OR chain.
module pgb_lowest_set #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N:0]   below;
  logic [N-1:0] hit;

  assign below[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign below[g+1] = below[g] | vec_i[g];
    assign hit[g]     = vec_i[g] & ~below[g];
  end

  assign any_o = below[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/pgb_page_store.sv
// Page-sized holding buffer with per-slot loaded flags and a wrapping pointer.
module pgb_page_store #(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic [OFS_W-1:0]  open_ofs_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              drop_i,
  input  logic              retire_i,
  input  logic [OFS_W-1:0]  retire_idx_i,
  input  logic [OFS_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [(1<<OFS_W)-1:0] loaded_o
);
  localparam int SLOTS = 1 << OFS_W;

  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  loaded_q;
  logic [OFS_W-1:0]  ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded_q <= '0;
      ptr_q    <= '0;
    end else if (open_i) begin
      loaded_q <= '0;
      ptr_q    <= open_ofs_i;
    end else if (drop_i) begin
      loaded_q <= '0;
    end else begin
      if (load_i) begin
        loaded_q[ptr_q] <= 1'b1;
        ptr_q           <= ptr_q + 1'b1;
      end
      if (retire_i) loaded_q[retire_idx_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load_i && !open_i) slot_q[ptr_q] <= load_data_i;
  end

  assign rd_data_o = slot_q[rd_idx_i];
  assign loaded_o  = loaded_q;
endmodule

// File: rtl/pgb_commit_ctrl.sv
// Sequencer for the commit and the fixed-length busy period.
module pgb_commit_ctrl
  import pgb_pkg::*;
#(
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic wp_i,
  input  logic pending_i,
  output logic idle_o,
  output logic busy_o,
  output logic drop_o,
  output logic writing_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  pgb_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             launch;

  assign idle_o    = (state_q == PGB_IDLE);
  assign busy_o    = !idle_o;
  assign launch    = idle_o && stop_i && pending_i && !wp_i;
  assign drop_o    = idle_o && stop_i && !launch;
  assign writing_o = (state_q == PGB_COMMIT) && pending_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PGB_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PGB_IDLE: begin
          if (launch) begin
            state_q <= PGB_COMMIT;
            cnt_q   <= CNT_W'(BUSY_CYCLES - 1);
          end
        end
        PGB_COMMIT: begin
          if (!pending_i) state_q <= PGB_HOLD;
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
        PGB_HOLD: begin
          if (cnt_q == '0) state_q <= PGB_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= PGB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgb_page_commit.sv
// Top: page write buffer with deferred, timed commit to the array.
module pgb_page_commit #(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 64,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start_i,
  input  logic [ADDR_W-1:0] txn_addr_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              stop_i,
  input  logic              wp_i,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o,
  output logic              busy_o
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int SLOTS  = 1 << OFS_W;
  localparam int BASE_W = ADDR_W - OFS_W;

  logic              idle;
  logic              open_txn;
  logic              load;
  logic              drop;
  logic              writing;
  logic              pending;
  logic [SLOTS-1:0]  loaded;
  logic [OFS_W-1:0]  next_idx;
  logic [DATA_W-1:0] rd_data;
  logic [BASE_W-1:0] base_q;

  assign open_txn   = idle && txn_start_i;
  assign in_ready_o = idle && !txn_start_i && !stop_i;
  assign load       = in_valid_i && in_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n)        base_q <= '0;
    else if (open_txn) base_q <= txn_addr_i[ADDR_W-1:OFS_W];
  end

  pgb_page_store #(
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W)
  ) store_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .open_i       (open_txn),
    .open_ofs_i   (txn_addr_i[OFS_W-1:0]),
    .load_i       (load),
    .load_data_i  (in_data_i),
    .drop_i       (drop),
    .retire_i     (writing),
    .retire_idx_i (next_idx),
    .rd_idx_i     (next_idx),
    .rd_data_o    (rd_data),
    .loaded_o     (loaded)
  );

  pgb_lowest_set #(
    .N     (SLOTS),
    .IDX_W (OFS_W)
  ) pick_i (
    .vec_i (loaded),
    .any_o (pending),
    .idx_o (next_idx)
  );

  pgb_commit_ctrl #(
    .BUSY_CYCLES (BUSY_CYCLES)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_i    (stop_i),
    .wp_i      (wp_i),
    .pending_i (pending),
    .idle_o    (idle),
    .busy_o    (busy_o),
    .drop_o    (drop),
    .writing_o (writing)
  );

  assign arr_we_o   = writing;
  assign arr_addr_o = {base_q, next_idx};
  assign arr_data_o = rd_data;
endmodule

// File: rtl/pgb_page_commit_chk.sv
module pgb_page_commit_chk #(
  parameter int ADDR_W      = 15,
  parameter int PAGE_BYTES  = 64,
  parameter int BUSY_CYCLES = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txn_start_i,
  input logic              in_ready_o,
  input logic              stop_i,
  input logic              wp_i,
  input logic              arr_we_o,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic              busy_o
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int RUN_W = $clog2(BUSY_CYCLES + 2) + 1;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R6
  busy_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !in_ready_o);

  // R3
  no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o);

  // R5
  busy_starts_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));

  // R5
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_q == RUN_W'(BUSY_CYCLES)));

  // R7
  wp_blocks_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !busy_o && wp_i) |=> !busy_o);

  // R4
  ascending_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we_o && $past(arr_we_o)) |->
      ((arr_addr_o[OFS_W-1:0] > $past(arr_addr_o[OFS_W-1:0])) &&
       (arr_addr_o[ADDR_W-1:OFS_W] == $past(arr_addr_o[ADDR_W-1:OFS_W]))));

  // R12
  ready_low_on_control_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_start_i || stop_i) |-> !in_ready_o);
endmodule

bind pgb_page_commit pgb_page_commit_chk #(
  .ADDR_W      (ADDR_W),
  .PAGE_BYTES  (PAGE_BYTES),
  .BUSY_CYCLES (BUSY_CYCLES)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .txn_start_i (txn_start_i),
  .in_ready_o  (in_ready_o),
  .stop_i      (stop_i),
  .wp_i        (wp_i),
  .arr_we_o    (arr_we_o),
  .arr_addr_o  (arr_addr_o),
  .busy_o      (busy_o)
);

// File: tb/pgb_page_commit_tb_top.sv
module pgb_page_commit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 15;
  localparam int DATA_W     = 8;
  localparam int BUSY       = 1000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              txn_start = 1'b0;
  logic [ADDR_W-1:0] txn_addr = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              stop = 1'b0;
  logic              wp = 1'b0;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_data;
  logic              busy;

  pgb_page_commit #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .PAGE_BYTES (64), .BUSY_CYCLES (BUSY)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .txn_start_i (txn_start), .txn_addr_i (txn_addr),
    .in_valid_i (in_valid), .in_ready_o (in_ready), .in_data_i (in_data),
    .stop_i (stop), .wp_i (wp), .arr_we_o (arr_we), .arr_addr_o (arr_addr),
    .arr_data_o (arr_data), .busy_o (busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int wr_n     = 0;
  int stop_cyc = 0;
  int busy_n   = 0;
  logic [ADDR_W-1:0] wr_addr [256];
  logic [DATA_W-1:0] wr_data [256];
  int                wr_cyc  [256];

  // Monitor samples on the falling edge, away from the active edge.
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (arr_we) begin
        if (wr_n < 256) begin
          wr_addr[wr_n] = arr_addr;
          wr_data[wr_n] = arr_data;
          wr_cyc[wr_n]  = cyc;
        end
        wr_n = wr_n + 1;
      end
      if (stop && !busy) stop_cyc = cyc;
      if (busy) busy_n = busy_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clr_log();
    wr_n   = 0;
    busy_n = 0;
  endtask

  task automatic start_txn(input logic [ADDR_W-1:0] a);
    txn_start = 1'b1;
    txn_addr  = a;
    tick();
    txn_start = 1'b0;
  endtask

  task automatic send(input logic [DATA_W-1:0] d);
    in_valid = 1'b1;
    in_data  = d;
    tick();
    in_valid = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1;
    tick();
    stop = 1'b0;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 5000 && busy; g++) tick();
    repeat (3) tick();
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R11", "busy after reset", int'(busy), 0);
    check(arr_we == 1'b0, "R11", "write strobe after reset", int'(arr_we), 0);
    check(in_ready == 1'b1, "R11", "ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_single();
    clr_log();
    start_txn(15'h0045);
    send(8'h11); send(8'h22); send(8'h33);
    repeat (4) tick();
    check(wr_n == 0, "R3", "writes before stop", wr_n, 0);
    check(busy == 1'b0, "R3", "busy before stop", int'(busy), 0);
    pulse_stop();
    wait_idle();
    check(wr_n == 3, "R4", "write count", wr_n, 3);
    for (int i = 0; i < 3; i++) begin
      check(wr_addr[i] == ADDR_W'(15'h0045 + i), "R1", "address",
            int'(wr_addr[i]), 'h45 + i);
      check(wr_data[i] == DATA_W'(8'h11 * (i + 1)), "R1", "data",
            int'(wr_data[i]), 'h11 * (i + 1));
      check(wr_cyc[i] == stop_cyc + 1 + i, "R4", "write cycle",
            wr_cyc[i], stop_cyc + 1 + i);
    end
    check(busy_n == BUSY, "R5", "busy length", busy_n, BUSY);
  endtask

  task automatic t_wrap();
    clr_log();
    start_txn(15'h1FBE);
    for (int k = 0; k < 66; k++) send(DATA_W'(k * 3 + 1));
    pulse_stop();
    wait_idle();
    check(wr_n == 64, "R2", "write count after wrap", wr_n, 64);
    for (int i = 0; i < 64; i++) begin
      int k;
      k = (i >= 62) ? (i - 62 + 64) : (i + 2);
      check(wr_addr[i] == ADDR_W'(15'h1F80 + i), "R2", "wrapped address",
            int'(wr_addr[i]), 'h1F80 + i);
      check(wr_data[i] == DATA_W'(k * 3 + 1), "R2", "wrapped data",
            int'(wr_data[i]), (k * 3 + 1) & 'hFF);
    end
  endtask

  task automatic t_protect();
    clr_log();
    start_txn(15'h0100);
    send(8'h5A); send(8'hA5);
    wp = 1'b1;
    pulse_stop();
    repeat (5) tick();
    check(busy_n == 0, "R7", "busy on protected stop", busy_n, 0);
    check(wr_n == 0, "R7", "writes on protected stop", wr_n, 0);
    wp = 1'b0;
    pulse_stop();
    repeat (5) tick();
    check(busy_n == 0, "R7", "busy after discard", busy_n, 0);
    check(wr_n == 0, "R7", "writes after discard", wr_n, 0);
  endtask

  task automatic t_empty();
    clr_log();
    start_txn(15'h0200);
    pulse_stop();
    repeat (5) tick();
    check(busy_n == 0, "R8", "busy on empty stop", busy_n, 0);
    check(wr_n == 0, "R8", "writes on empty stop", wr_n, 0);
  endtask

  task automatic t_abandon();
    clr_log();
    start_txn(15'h0300);
    send(8'hAA); send(8'hBB);
    start_txn(15'h0480);
    send(8'hCC);
    pulse_stop();
    wait_idle();
    check(wr_n == 1, "R9", "writes after restart", wr_n, 1);
    check(wr_addr[0] == 15'h0480, "R9", "restart address", int'(wr_addr[0]), 'h480);
    check(wr_data[0] == 8'hCC, "R9", "restart data", int'(wr_data[0]), 'hCC);
  endtask

  task automatic t_busy_ignore();
    clr_log();
    start_txn(15'h0040);
    send(8'h5A);
    pulse_stop();
    check(in_ready == 1'b0, "R6", "ready while busy", int'(in_ready), 0);
    txn_start = 1'b1; txn_addr = 15'h7000;
    in_valid = 1'b1; in_data = 8'hEE; stop = 1'b1;
    repeat (3) tick();
    txn_start = 1'b0; in_valid = 1'b0; stop = 1'b0;
    wait_idle();
    check(busy_n == BUSY, "R6", "busy length with ignored stop", busy_n, BUSY);
    check(wr_n == 1, "R6", "writes with ignored input", wr_n, 1);
    check(wr_addr[0] == 15'h0040, "R6", "address unaffected", int'(wr_addr[0]), 'h40);
    clr_log();
    pulse_stop();
    repeat (5) tick();
    check(wr_n == 0, "R10", "writes after commit", wr_n, 0);
    check(busy_n == 0, "R10", "busy after commit", busy_n, 0);
  endtask

  task automatic t_ready_control();
    clr_log();
    txn_start = 1'b1; txn_addr = 15'h0500;
    in_valid = 1'b1; in_data = 8'h77;
    #1;
    check(in_ready == 1'b0, "R12", "ready during start", int'(in_ready), 0);
    tick();
    txn_start = 1'b0; in_valid = 1'b0;
    pulse_stop();
    repeat (5) tick();
    check(wr_n == 0, "R12", "byte taken with start", wr_n, 0);
    check(busy_n == 0, "R12", "busy after rejected byte", busy_n, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single();
    t_wrap();
    t_protect();
    t_empty();
    t_abandon();
    t_busy_ignore();
    t_ready_control();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule